// File: doc/BRIEF.md
# Jitter Attenuator Elastic FIFO

This block is a bit-serial elastic store that smooths a jittery T1-rate bit stream. Bits arrive on single-cycle write pulses that may come in bursts or with gaps. They leave on a read strobe made by dividing a 16x reference clock. Normally the divide ratio is 16. When the fill level has moved far from the centre of the store, the divider reads one period faster (divide by 15) or one period slower (divide by 17) until the fill comes back inside the window. Each such stretched or shortened period sets a sticky limit-trip flag, and a dedicated clear input resets the flag.

The store holds either 32 or 128 bits, picked by one select input. The small depth suits paths that are sensitive to delay. The large depth absorbs wide wander. After reset, and after any change of depth, the store is refilled with zeros to half depth, so the first half-depth reads return 0. A bypass input takes the store out of the path. The write pulse and bit then appear on the read outputs one cycle later.

Top module: `jitter_elastic_fifo`

## Requirements
- R1: While reset is held and in the first cycle after it (select low), fill reads 16, the trip flag is 0 and the read strobe is 0.
- R2: While the fill stays inside the window, the read strobe is a one-cycle pulse every 16 clock cycles. This holds under both steady and bursty writes.
- R3: Bits leave in the order they were written. After reset the first half-depth strobes carry 0, and read j after that carries write j.
- R4: Fill goes up by one on an accepted write and down by one on a strobe that finds data. A write is dropped when the store is full and no read happens that cycle. A strobe on an empty store leaves fill at 0. Fill never exceeds the selected depth.
- R5: If fill at the end of a read period is above centre plus half the limit (30 for depth 32, 124 for depth 128), the next period lasts 15 cycles.
- R6: If fill at the end of a read period is below centre minus half the limit (2 for depth 32, 4 for depth 128), the next period lasts 17 cycles.
- R7: The trip flag rises only together with the read strobe that starts a 15- or 17-cycle period. It then holds until the clear input is high. A trip and a clear in the same cycle leave the flag set.
- R8: Select low gives depth 32 and select high gives depth 128. Changing the select refills the store, so fill reads half the new depth two cycles later.
- R9: With bypass high, each cycle the read strobe and read bit equal the write pulse and write bit of the previous cycle. Fill is held at half depth and the trip flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16x reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write pulse |
| wr_data | input | 1 | Bit written with wr_en |
| deep_sel | input | 1 | 0: 32-bit store, 1: 128-bit store |
| bypass | input | 1 | Route write side straight to read side |
| trip_clr | input | 1 | Clears the limit-trip flag |
| rd_data | output | 1 | Bit read out, valid with rd_strobe |
| rd_strobe | output | 1 | Smoothed read pulse |
| fill | output | 8 | Bits currently held |
| trip | output | 1 | Sticky limit-trip flag |

## Verification
The bench runs the store into both edges of the window. A 40-bit burst fills the small store to full. A long write silence drains it to empty. A design with a wrong threshold, or with the 15 and 17 ratios swapped, then shows a period of the wrong length. A design that lets the pointers wrap would show a fill above 32 or a fill going below zero. The flag clear is held high through a trip to catch a design where the clear wins. The bench also toggles the depth select and bypass: a design that failed to refill on a depth change would show the old fill, and one that kept the store in the path while bypassed would show an extra delay.

// File: rtl/jef_pkg.sv
package jef_pkg;
   typedef enum logic [1:0] {
      DIV_NOM  = 2'd0,
      DIV_FAST = 2'd1,
      DIV_SLOW = 2'd2
   } div_mode_t;
endpackage

// File: rtl/jef_store.sv
module jef_store #(
   parameter int SHALLOW_DEPTH = 32,
   parameter int DEEP_DEPTH    = 128,
   parameter int FILL_W        = $clog2(DEEP_DEPTH + 1),
   parameter int ADDR_W        = $clog2(DEEP_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reinit,
   input  logic              deep_sel,
   input  logic              wr_en,
   input  logic              wr_data,
   input  logic              rd_en,
   output logic              rd_bit,
   output logic [FILL_W-1:0] fill
);
   localparam logic [FILL_W-1:0] SHAL_F = FILL_W'(SHALLOW_DEPTH);
   localparam logic [FILL_W-1:0] DEEP_F = FILL_W'(DEEP_DEPTH);

   logic              mem [DEEP_DEPTH];
   logic [ADDR_W-1:0] wr_ptr, rd_ptr, mask, half_ptr;
   logic [FILL_W-1:0] depth_now;
   logic              do_rd, do_wr;

   assign depth_now = deep_sel ? DEEP_F : SHAL_F;
   assign mask      = deep_sel ? ADDR_W'(DEEP_DEPTH - 1) : ADDR_W'(SHALLOW_DEPTH - 1);
   assign half_ptr  = ADDR_W'(depth_now >> 1);
   assign do_rd     = rd_en && (fill != '0);
   assign do_wr     = wr_en && ((fill != depth_now) || do_rd);

   for (genvar b = 0; b < DEEP_DEPTH; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               mem[b] <= 1'b0;
         else if (reinit)                          mem[b] <= 1'b0;
         else if (do_wr && wr_ptr == ADDR_W'(b))   mem[b] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= ADDR_W'(SHALLOW_DEPTH / 2);
         rd_ptr <= '0;
         fill   <= FILL_W'(SHALLOW_DEPTH / 2);
         rd_bit <= 1'b0;
      end else if (reinit) begin
         wr_ptr <= half_ptr;
         rd_ptr <= '0;
         fill   <= FILL_W'(half_ptr);
      end else begin
         if (do_wr) wr_ptr <= (wr_ptr + 1'b1) & mask;
         if (do_rd) begin
            rd_ptr <= (rd_ptr + 1'b1) & mask;
            rd_bit <= mem[rd_ptr];
         end
         case ({do_wr, do_rd})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/jef_fill_monitor.sv
module jef_fill_monitor
   import jef_pkg::*;
#(
   parameter int SHALLOW_DEPTH = 32,
   parameter int DEEP_DEPTH    = 128,
   parameter int SHALLOW_LIMIT = 28,
   parameter int DEEP_LIMIT    = 120,
   parameter int FILL_W        = $clog2(DEEP_DEPTH + 1)
) (
   input  logic [FILL_W-1:0] fill,
   input  logic              deep_sel,
   output div_mode_t         mode
);
   localparam logic [FILL_W-1:0] S_HI = FILL_W'(SHALLOW_DEPTH / 2 + SHALLOW_LIMIT / 2);
   localparam logic [FILL_W-1:0] S_LO = FILL_W'(SHALLOW_DEPTH / 2 - SHALLOW_LIMIT / 2);
   localparam logic [FILL_W-1:0] D_HI = FILL_W'(DEEP_DEPTH / 2 + DEEP_LIMIT / 2);
   localparam logic [FILL_W-1:0] D_LO = FILL_W'(DEEP_DEPTH / 2 - DEEP_LIMIT / 2);

   logic [FILL_W-1:0] hi, lo;
   assign hi = deep_sel ? D_HI : S_HI;
   assign lo = deep_sel ? D_LO : S_LO;

   always_comb begin
      if (fill > hi)      mode = DIV_FAST;
      else if (fill < lo) mode = DIV_SLOW;
      else                mode = DIV_NOM;
   end
endmodule

// File: rtl/jef_divider.sv
module jef_divider
   import jef_pkg::*;
#(
   parameter int NOM_DIV = 16,
   parameter int CNT_W   = $clog2(NOM_DIV + 2)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      hold,
   input  div_mode_t mode,
   output logic      tick
);
   logic [CNT_W-1:0] cnt, last_q, last_nx;

   always_comb begin
      case (mode)
         DIV_FAST: last_nx = CNT_W'(NOM_DIV - 2);
         DIV_SLOW: last_nx = CNT_W'(NOM_DIV);
         default:  last_nx = CNT_W'(NOM_DIV - 1);
      endcase
   end

   assign tick = !hold && (cnt == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         last_q <= CNT_W'(NOM_DIV - 1);
      end else if (hold) begin
         cnt    <= '0;
         last_q <= CNT_W'(NOM_DIV - 1);
      end else if (tick) begin
         cnt    <= '0;
         last_q <= last_nx;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/jitter_elastic_fifo.sv
module jitter_elastic_fifo
   import jef_pkg::*;
#(
   parameter int SHALLOW_DEPTH = 32,
   parameter int DEEP_DEPTH    = 128,
   parameter int SHALLOW_LIMIT = 28,
   parameter int DEEP_LIMIT    = 120,
   parameter int NOM_DIV       = 16,
   parameter int FILL_W        = $clog2(DEEP_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_data,
   input  logic              deep_sel,
   input  logic              bypass,
   input  logic              trip_clr,
   output logic              rd_data,
   output logic              rd_strobe,
   output logic [FILL_W-1:0] fill,
   output logic              trip
);
   if ((SHALLOW_DEPTH & (SHALLOW_DEPTH - 1)) != 0 || (DEEP_DEPTH & (DEEP_DEPTH - 1)) != 0)
      $error("depths must be powers of two");
   if (SHALLOW_DEPTH >= DEEP_DEPTH)
      $error("shallow depth must be below deep depth");
   if (SHALLOW_LIMIT >= SHALLOW_DEPTH || DEEP_LIMIT >= DEEP_DEPTH)
      $error("limit must be below depth");
   if (NOM_DIV < 4)
      $error("nominal divide too small");

   div_mode_t mode;
   logic      deep_q, reinit, tick, store_bit;
   logic      byp_q, byp_bit, byp_stb, stb_q;

   assign reinit = bypass || (deep_sel != deep_q);

   jef_store #(
      .SHALLOW_DEPTH(SHALLOW_DEPTH), .DEEP_DEPTH(DEEP_DEPTH), .FILL_W(FILL_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .reinit(reinit), .deep_sel(deep_sel),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(tick),
      .rd_bit(store_bit), .fill(fill)
   );

   jef_fill_monitor #(
      .SHALLOW_DEPTH(SHALLOW_DEPTH), .DEEP_DEPTH(DEEP_DEPTH),
      .SHALLOW_LIMIT(SHALLOW_LIMIT), .DEEP_LIMIT(DEEP_LIMIT), .FILL_W(FILL_W)
   ) u_mon (
      .fill(fill), .deep_sel(deep_sel), .mode(mode)
   );

   jef_divider #(.NOM_DIV(NOM_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .hold(reinit), .mode(mode), .tick(tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         deep_q  <= 1'b0;
         byp_q   <= 1'b0;
         byp_bit <= 1'b0;
         byp_stb <= 1'b0;
         stb_q   <= 1'b0;
         trip    <= 1'b0;
      end else begin
         deep_q  <= deep_sel;
         byp_q   <= bypass;
         byp_bit <= wr_data;
         byp_stb <= wr_en;
         stb_q   <= tick;
         if (tick && mode != DIV_NOM) trip <= 1'b1;
         else if (trip_clr)           trip <= 1'b0;
      end
   end

   assign rd_strobe = byp_q ? byp_stb : stb_q;
   assign rd_data   = byp_q ? byp_bit : store_bit;
endmodule

// File: rtl/jef_checker.sv
module jef_checker #(
   parameter int SHALLOW_DEPTH = 32,
   parameter int DEEP_DEPTH    = 128,
   parameter int FILL_W        = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              deep_sel,
   input logic              bypass,
   input logic              trip_clr,
   input logic              rd_strobe,
   input logic [FILL_W-1:0] fill,
   input logic              trip
);
   p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(deep_sel) |-> int'(fill) <= (deep_sel ? DEEP_DEPTH : SHALLOW_DEPTH));

   p_fill_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && !$past(bypass) && $stable(deep_sel) && $past($stable(deep_sel)))
      |-> (int'(fill) == int'($past(fill)) || int'(fill) == int'($past(fill)) + 1
           || int'(fill) + 1 == int'($past(fill))));

   p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !bypass) |=> !rd_strobe);

   p_trip_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trip && !trip_clr) |=> trip);

   p_trip_at_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trip) |-> rd_strobe);

   p_bypass_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass && $past(bypass)) |-> (rd_strobe == $past(wr_en)));
endmodule

bind jitter_elastic_fifo jef_checker #(
   .SHALLOW_DEPTH(SHALLOW_DEPTH), .DEEP_DEPTH(DEEP_DEPTH), .FILL_W(FILL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .deep_sel(deep_sel), .bypass(bypass),
   .trip_clr(trip_clr), .rd_strobe(rd_strobe), .fill(fill), .trip(trip)
);

// File: tb/sim_jitter_elastic_fifo.sv
`timescale 1ns/1ps
module sim_jitter_elastic_fifo;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_data = 1'b0, deep_sel = 1'b0, bypass = 1'b0, trip_clr = 1'b0;
   logic       rd_data, rd_strobe, trip;
   logic [7:0] fill;
   int         npass = 0, nfail = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   jitter_elastic_fifo u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .deep_sel(deep_sel),
      .bypass(bypass), .trip_clr(trip_clr), .rd_data(rd_data), .rd_strobe(rd_strobe),
      .fill(fill), .trip(trip)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      if (ok) npass++;
      else begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; wr_en = 1'b0; wr_data = 1'b0; deep_sel = 1'b0;
      bypass = 1'b0; trip_clr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_strobe(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!rd_strobe && n < 100);
   endtask

   function automatic bit pat(input int k);
      return k[0] ^ k[2] ^ k[3] ^ k[5];
   endfunction

   task automatic burst(input int len);
      wr_en = 1'b1;
      for (int i = 0; i < len; i++) begin
         wr_data = pat(i);
         @(negedge clk);
      end
      wr_en = 1'b0;
   endtask

   initial begin
      int n, nrd, nwr, last_c;
      bit pe, pd;
      // R1 reset state
      do_reset();
      check(fill == 8'd16, "R1 fill", fill, 16);
      check(trip == 1'b0, "R1 trip", trip, 0);
      check(rd_strobe == 1'b0, "R1 strobe", rd_strobe, 0);
      @(negedge clk);
      check(fill == 8'd16, "R1 fill after release", fill, 16);
      // R4 single write
      wr_en = 1'b1; wr_data = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      check(fill == 8'd17, "R4 write increments", fill, 17);

      // R2/R3 gapped bursts of 4 every 64 cycles
      do_reset();
      nrd = 0; nwr = 0; last_c = -1;
      for (int c = 0; c < 740; c++) begin
         @(negedge clk);
         if (rd_strobe) begin
            if (nrd < 16) check(rd_data == 1'b0, "R3 preset zero", rd_data, 0);
            else          check(rd_data == pat(nrd - 16), "R3 order", rd_data, pat(nrd - 16));
            if (last_c >= 0) check(c - last_c == 16, "R2 period", c - last_c, 16);
            last_c = c;
            nrd++;
         end
         wr_en = ((c % 64) < 4);
         wr_data = pat(nwr);
         if (wr_en) nwr++;
      end
      wr_en = 1'b0;
      check(trip == 1'b0, "R2 no trip in window", trip, 0);

      // R4 full, R5 fast, R7 clear
      do_reset();
      burst(40);
      check(fill == 8'd32, "R4 capped at depth", fill, 32);
      wait_strobe(n);
      wait_strobe(n);
      check(n == 15, "R5 fast period", n, 15);
      check(trip == 1'b1, "R7 trip on fast", trip, 1);
      trip_clr = 1'b1;
      @(negedge clk);
      trip_clr = 1'b0;
      check(trip == 1'b0, "R7 clear", trip, 0);

      // R6 slow, R4 empty, R7 set beats clear
      do_reset();
      trip_clr = 1'b1;
      for (int i = 0; i < 30 && fill != 8'd0; i++) wait_strobe(n);
      wait_strobe(n);
      wait_strobe(n);
      check(n == 17, "R6 slow period", n, 17);
      check(trip == 1'b1, "R7 set wins over clear", trip, 1);
      check(fill == 8'd0, "R4 empty holds zero", fill, 0);
      trip_clr = 1'b0;

      // R8 depth switch, R5 deep
      deep_sel = 1'b1;
      repeat (2) @(negedge clk);
      check(fill == 8'd64, "R8 deep refill", fill, 64);
      burst(66);
      check(fill > 8'd124 && fill <= 8'd128, "R8 deep capacity", fill, 125);
      wait_strobe(n);
      wait_strobe(n);
      check(n == 15, "R5 deep fast period", n, 15);
      deep_sel = 1'b0;
      repeat (2) @(negedge clk);
      check(fill == 8'd16, "R8 shallow refill", fill, 16);

      // R9 bypass
      trip_clr = 1'b1;
      @(negedge clk);
      trip_clr = 1'b0;
      bypass = 1'b1;
      repeat (2) @(negedge clk);
      pe = 1'b0; pd = 1'b0;
      for (int i = 0; i < 24; i++) begin
         wr_en = (i % 3) != 1;
         wr_data = pat(i + 7);
         pe = wr_en; pd = wr_data;
         @(negedge clk);
         check(rd_strobe == pe, "R9 strobe follows", rd_strobe, pe);
         check(rd_data == pd, "R9 data follows", rd_data, pd);
      end
      wr_en = 1'b0;
      check(fill == 8'd16, "R9 fill held", fill, 16);
      check(trip == 1'b0, "R9 no trip", trip, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", npass, npass + nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", npass, npass + nfail);
         $finish;
      end
   end
endmodule